// File: doc/BRIEF.md
# Edge-Latching Capture Timer

The block runs a free-running up-counter on the system clock and watches a single asynchronous capture input. Each input transition is brought into the clock domain through a synchronizer, classified as rising or falling, and used to copy the current counter value into one of two holding registers. Rising and falling transitions have separate holding registers, so software can subtract one from the other to get a pulse width or a period.

Each capture raises a level interrupt. The interrupt stays high until it is cleared through a dedicated clear input. A flag records whether the most recent capture came from a rising or a falling edge. A second flag reports that a capture happened while the previous interrupt was still pending. A single enable input freezes or runs the counter.

Inputs that stay high or low for fewer than four clocks, or that repeat in fewer than eight clocks, are outside the operating range. Such inputs need not be captured correctly.

Top module: `cap_timer`

## Requirements
- R1: `count` is CNT_W bits wide (16 by default), resets to 0, and rises by one on every clock edge while `run` is 1. It wraps from all ones to 0.
- R2: While `run` is 0, `count` holds its value. Captures still take place and latch the frozen value.
- R3: A 0-to-1 change on `cap_in`, applied between clock edges, loads `rise_val` at the third rising clock edge after the change. This is within 4 clocks. The loaded value is the `count` present just before that edge: with `run` high, this is the count seen at the change plus 2.
- R4: A 1-to-0 change on `cap_in` loads `fall_val` with the same timing and value rule as R3. It leaves `rise_val` untouched. A rising capture likewise leaves `fall_val` untouched.
- R5: `edge_rise` is 1 after a rising-edge capture and 0 after a falling-edge capture.
- R6: `irq` goes high at the same edge that loads a capture register, and not earlier. It stays high until a clock edge where `irq_clr` is 1. A capture at that same edge keeps it high.
- R7: `overrun` is set when a capture occurs while `irq` is still high and `irq_clr` is not asserted. It is cleared, together with `irq`, by `irq_clr`.
- R8: After reset, `count`, `rise_val`, `fall_val`, `edge_rise`, `irq` and `overrun` are all 0.
- R9: The input passes through two synchronizer flops plus one edge-history flop. Every transition of an input that respects the 4-clock high and low minimums is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter enable |
| cap_in | input | 1 | Asynchronous capture input |
| irq_clr | input | 1 | Clears `irq` and `overrun` |
| count | output | CNT_W | Free-running counter value |
| rise_val | output | CNT_W | Counter value latched on the latest rising edge |
| fall_val | output | CNT_W | Counter value latched on the latest falling edge |
| edge_rise | output | 1 | 1 if the latest capture was a rising edge |
| irq | output | 1 | Capture interrupt request |
| overrun | output | 1 | Capture occurred while interrupt pending |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two synchronizer stages. This makes the three-edge capture latency an exact, checkable number. With a 16-bit counter, the wrap from 0xFFFF to 0 is reached in about 65 thousand clocks, so a capture that straddles the wrap fits inside the run. The bench also covers captures with the counter halted, and a second capture taken before the first interrupt is cleared, to reach the overrun path.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cap_in,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rise_val,
  output logic [CNT_W-1:0] fall_val,
  output logic             edge_rise,
  output logic             irq,
  output logic             overrun
);
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS-1:0] sync_q;
  logic          hist_q;
  logic          lvl, rise_evt, fall_evt, cap_evt;

  assign lvl      = sync_q[SS-1];
  assign rise_evt = lvl & ~hist_q;
  assign fall_evt = ~lvl & hist_q;
  assign cap_evt  = rise_evt | fall_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SS-2:0], cap_in};
      hist_q <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_val  <= '0;
      fall_val  <= '0;
      edge_rise <= 1'b0;
    end else begin
      if (rise_evt) rise_val <= count;
      if (fall_evt) fall_val <= count;
      if (cap_evt)  edge_rise <= rise_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      irq     <= cap_evt | (irq & ~irq_clr);
      overrun <= (cap_evt & irq & ~irq_clr) | (overrun & ~irq_clr);
    end
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rise_val,
  input logic [CNT_W-1:0] fall_val,
  input logic             edge_rise,
  input logic             irq,
  input logic             overrun
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> count == CNT_W'($past(count) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  a_r3_rise_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rise_val) |-> irq && edge_rise);

  a_r4_fall_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fall_val) |-> irq && !edge_rise);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  a_r7_ovr_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> irq);

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !irq_clr |=> overrun);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .irq_clr(irq_clr), .count(count),
  .rise_val(rise_val), .fall_val(fall_val), .edge_rise(edge_rise),
  .irq(irq), .overrun(overrun)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, cap_in = 1'b0, irq_clr = 1'b0;
  logic [W-1:0] count, rise_val, fall_val;
  logic edge_rise, irq, overrun;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W:0] exp_q[$];
  logic [W-1:0] exp_rise = '0, exp_fall = '0;
  logic irq_q = 1'b0;

  always #2.5 clk = ~clk;

  cap_timer #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cap_in(cap_in), .irq_clr(irq_clr),
    .count(count), .rise_val(rise_val), .fall_val(fall_val),
    .edge_rise(edge_rise), .irq(irq), .overrun(overrun)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per new interrupt
  always @(negedge clk) begin
    if (rst_n && irq && !irq_q && exp_q.size() > 0) begin
      logic [W:0] it;
      it = exp_q.pop_front();
      if (it[W]) exp_rise = it[W-1:0]; else exp_fall = it[W-1:0];
      check(it[W] ? "R3 rise_val" : "R4 fall_val", it[W] ? rise_val : fall_val, it[W-1:0]);
      check("R4 other register untouched", it[W] ? fall_val : rise_val, it[W] ? exp_fall : exp_rise);
      check("R5 edge_rise", W'(edge_rise), W'(it[W]));
    end
    irq_q = irq;
  end

  // driver: one edge, expected item pushed, latency checked, irq cleared
  task automatic drive_edge(input logic v);
    logic [W-1:0] c;
    @(negedge clk);
    c = count;
    cap_in = v;
    exp_q.push_back({v, run ? W'(c + 2) : c});
    repeat (2) @(negedge clk);
    check("R6 irq not early", W'(irq), '0);
    @(negedge clk);
    check("R3 irq within 4 clocks", W'(irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R6 irq cleared", W'(irq), '0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 count", count, '0);
    check("R8 rise_val", rise_val, '0);
    check("R8 fall_val", fall_val, '0);
    check("R8 flags", W'({edge_rise, irq, overrun}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    begin
      logic [W-1:0] c0;
      c0 = count;
      run = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 counts while run", count, W'(c0 + 5));
    end
    // R3/R4/R9: pulses of several widths, all at the 4-clock minimum or more
    drive_edge(1'b1); drive_edge(1'b0);
    drive_edge(1'b1); repeat (9) @(negedge clk); drive_edge(1'b0);
    repeat (20) @(negedge clk);
    drive_edge(1'b1); drive_edge(1'b0);
    // R9: back-to-back minimum-width pulses, no clear in between
    begin
      logic [W-1:0] c;
      @(negedge clk);
      c = count; cap_in = 1'b1;
      repeat (4) @(negedge clk);
      cap_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R9 min-width rise", rise_val, W'(c + 2));
      check("R9 min-width fall", fall_val, W'(c + 6));
      check("R7 overrun on second capture", W'(overrun), 1);
      exp_rise = rise_val; exp_fall = fall_val;
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      check("R7 overrun cleared", W'({irq, overrun}), '0);
      repeat (3) @(negedge clk);
    end
    // R2: halted counter
    run = 1'b0;
    @(negedge clk);
    begin
      logic [W-1:0] c;
      c = count;
      drive_edge(1'b1);
      check("R2 count held", count, c);
      drive_edge(1'b0);
    end
    run = 1'b1;
    // R7: capture while irq pending
    drive_edge(1'b1);
    @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 irq pending", W'(irq), 1);
    check("R7 no overrun after first", W'(overrun), '0);
    @(negedge clk);
    begin
      logic [W-1:0] c;
      c = count; cap_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 overrun set", W'(overrun), 1);
      check("R3 rise during pending", rise_val, W'(c + 2));
      check("R5 latest is rise", W'(edge_rise), 1);
      exp_rise = rise_val;
    end
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R7 clear", W'({irq, overrun}), '0);
    repeat (4) @(negedge clk);
    // R1: wrap across all ones
    while (count != {W{1'b1}} - 1) @(negedge clk);
    drive_edge(1'b0);
    check("R1 wrapped", W'(count < 16), 1);
    repeat (4) @(negedge clk);
    check("R1 queue drained", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule